// File: doc/BRIEF.md
# Serial Command Register Interface

This block is a serial slave that lets a host read and write a small bank of 16-bit control registers. The host pulls chip select low and clocks in 32 bits, most significant bit first: an 8-bit instruction, an 8-bit register address and one 16-bit data word. A write stores the word into the selected register. A read returns the register contents on the serial output during the data phase.

The serial clock, chip select and serial input are sampled by a faster system clock through two-flop synchronizers, and edges are detected in the system domain. The host may therefore stop the serial clock between edges for as long as it likes. When chip select rises after a complete, recognised transaction, a ready output drops for a fixed number of system clocks. That number depends on the operation. The host must not finish another transaction until ready has returned high. The full register bank is also presented as a flat vector for the logic the registers control.

Top module: `sci_regif`

## Requirements
- R1: After reset every register is zero, `rdy_o` is 1 and `sdo_oe_o` is 0.
- R2: The instruction 0x02 (write), followed by an address and a 16-bit word, all sent MSB first with bits taken on the serial clock rising edge, stores that word into the addressed register when chip select rises. Only the first 32 rising edges of a transaction are used; later edges are ignored.
- R3: The instruction 0x03 (read) drives the addressed register on `sdo_o`, MSB first. Each bit is updated after a serial clock falling edge, starting with the falling edge that follows the 16th rising edge, so the host can sample it on the next rising edge.
- R4: Only the low four address bits select the register. The upper four address bits have no effect.
- R5: After a write, `rdy_o` is low for exactly WR_BUSY system clocks and then returns high.
- R6: After a read, `rdy_o` is low for exactly RD_BUSY system clocks and then returns high.
- R7: A complete transaction whose instruction is neither 0x02 nor 0x03 changes no register and leaves `rdy_o` high.
- R8: If chip select rises after fewer than 32 rising edges, no register changes and `rdy_o` stays high.
- R9: Any pause between serial clock edges, while chip select stays low, does not change the result of a transaction.
- R10: `sdo_oe_o` is high while the synchronized chip select is low, and low while it is high.
- R11: `regs_o[16*i +: 16]` always shows register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in from the host |
| sdo_o | output | 1 | Serial data out to the host |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` (pad is high impedance when 0) |
| rdy_o | output | 1 | Ready; low while the block is busy after an operation |
| regs_o | output | NUM_REGS*DATA_W | All registers, register i at bits [DATA_W*i +: DATA_W] |

## Verification
The bench builds the block with 16 registers of 16 bits, a read busy length of 3 and a write busy length of 11. Because the busy lengths differ from each other and from the defaults, a wrong busy value or a swapped load would show up as an exact cycle-count mismatch. With only 16 registers, every index can be written twice, with complementary data and varied upper address nibbles, and then read back. Every abort length class, several unknown opcodes, long clock pauses and over-long frames are also applied, each against a model of the register contents kept in the bench.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int INSTR_W = 8;
  localparam int ADDR_W  = 8;
  localparam int HDR_W   = INSTR_W + ADDR_W;

  localparam logic [INSTR_W-1:0] OP_WRITE = 8'h02;
  localparam logic [INSTR_W-1:0] OP_READ  = 8'h03;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;
endpackage

// File: rtl/sci_sync.sv
module sci_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/sci_frame.sv
module sci_frame
  import sci_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              sck_s_i,
  input  logic              sdi_s_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [IDX_W-1:0]  ridx_o,
  output logic [IDX_W-1:0]  widx_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wr_o,
  output logic              rd_done_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int SH_W    = FRAME_W - 1;

  logic              sck_d_q, cs_d_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   sh_q;
  logic              hdr_q;
  cmd_e              cmd_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] out_q;
  logic              sdo_q;

  logic sck_rise, sck_fall, cs_fall, cs_rise, full, in_data;
  cmd_e hdr_cmd;

  assign sck_rise = sck_s_i & ~sck_d_q & ~cs_s_i;
  assign sck_fall = ~sck_s_i & sck_d_q & ~cs_s_i;
  assign cs_fall  = ~cs_s_i & cs_d_q;
  assign cs_rise  = cs_s_i & ~cs_d_q;
  assign full     = (cnt_q == CNT_W'(FRAME_W));
  assign in_data  = (cnt_q >= CNT_W'(HDR_W)) && !full;

  always_comb begin
    unique case (sh_q[HDR_W-1:ADDR_W])
      OP_READ:  hdr_cmd = CMD_READ;
      OP_WRITE: hdr_cmd = CMD_WRITE;
      default:  hdr_cmd = CMD_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b1;
      cnt_q   <= '0;
      sh_q    <= '0;
      hdr_q   <= 1'b0;
      cmd_q   <= CMD_NONE;
      idx_q   <= '0;
      out_q   <= '0;
      sdo_q   <= 1'b0;
    end else begin
      sck_d_q <= sck_s_i;
      cs_d_q  <= cs_s_i;
      hdr_q   <= 1'b0;
      if (cs_fall) begin
        cnt_q <= '0;
        cmd_q <= CMD_NONE;
        sdo_q <= 1'b0;
      end else if (sck_rise && !full) begin
        sh_q  <= {sh_q[SH_W-2:0], sdi_s_i};
        cnt_q <= cnt_q + 1'b1;
        hdr_q <= (cnt_q == CNT_W'(HDR_W - 1));
      end
      // header complete: latch command, fetch read word
      if (hdr_q) begin
        cmd_q <= hdr_cmd;
        idx_q <= sh_q[IDX_W-1:0];
        out_q <= (hdr_cmd == CMD_READ) ? rdata_i : '0;
      end else if (sck_fall && in_data) begin
        sdo_q <= out_q[DATA_W-1];
        out_q <= {out_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign ridx_o    = sh_q[IDX_W-1:0];
  assign widx_o    = idx_q;
  assign wdata_o   = sh_q[DATA_W-1:0];
  assign wr_o      = cs_rise & full & (cmd_q == CMD_WRITE);
  assign rd_done_o = cs_rise & full & (cmd_q == CMD_READ);
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = ~cs_s_i;

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_W));
  a_r3_sdo_only_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_fall && !cs_fall) |=> $stable(sdo_q));
  a_r9_idle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_rise && !cs_fall) |=> $stable(cnt_q));
endmodule

// File: rtl/sci_regbank.sv
module sci_regbank #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           widx_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [IDX_W-1:0]           ridx_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] bank_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            bank_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))   bank_q[g] <= wdata_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = bank_q[g];
  end

  assign rdata_o = bank_q[ridx_i];

  a_r11_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_o));
endmodule

// File: rtl/sci_busy.sv
module sci_busy #(
  parameter int RD_BUSY = 4,
  parameter int WR_BUSY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_rd_i,
  input  logic start_wr_i,
  output logic rdy_o
);
  localparam int MAX_B = (RD_BUSY > WR_BUSY) ? RD_BUSY : WR_BUSY;
  localparam int CW    = $clog2(MAX_B + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_wr_i)     cnt_q <= CW'(WR_BUSY);
    else if (start_rd_i)     cnt_q <= CW'(RD_BUSY);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign rdy_o = (cnt_q == '0);

  a_r5_write_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_i |=> cnt_q == CW'(WR_BUSY));
  a_r6_read_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_rd_i && !start_wr_i) |=> cnt_q == CW'(RD_BUSY));
  a_r5_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !start_rd_i && !start_wr_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/sci_regif.sv
module sci_regif #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 16,
  parameter int RD_BUSY  = 4,
  parameter int WR_BUSY  = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       sck_i,
  input  logic                       sdi_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  output logic                       rdy_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [2:0]        pins_s;
  logic              cs_s, sck_s, sdi_s;
  logic [IDX_W-1:0]  ridx, widx;
  logic [DATA_W-1:0] rdata, wdata;
  logic              wr, rd_done;

  sci_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i, sdi_i}),
    .q_o    (pins_s)
  );
  assign {cs_s, sck_s, sdi_s} = pins_s;

  sci_frame #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s_i    (cs_s),
    .sck_s_i   (sck_s),
    .sdi_s_i   (sdi_s),
    .rdata_i   (rdata),
    .ridx_o    (ridx),
    .widx_o    (widx),
    .wdata_o   (wdata),
    .wr_o      (wr),
    .rd_done_o (rd_done),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o)
  );

  sci_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr),
    .widx_i  (widx),
    .wdata_i (wdata),
    .ridx_i  (ridx),
    .rdata_o (rdata),
    .regs_o  (regs_o)
  );

  sci_busy #(.RD_BUSY(RD_BUSY), .WR_BUSY(WR_BUSY)) i_busy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_rd_i (rd_done),
    .start_wr_i (wr),
    .rdy_o      (rdy_o)
  );

  a_r8_write_at_cs_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |-> cs_s);
  a_r7_single_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr, rd_done}));
  a_r5_busy_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> !rdy_o);
endmodule

// File: tb/test_sci_regif.sv
`timescale 1ns/1ps
module test_sci_regif;
  localparam int NREG = 16;
  localparam int DW   = 16;
  localparam int RDB  = 3;
  localparam int WRB  = 11;
  localparam int H    = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, rdy;
  logic [NREG*DW-1:0] regs;

  always #2 clk = ~clk;

  sci_regif #(.NUM_REGS(NREG), .DATA_W(DW), .RD_BUSY(RDB), .WR_BUSY(WRB)) i_sci_regif (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rdy_o(rdy), .regs_o(regs)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [DW-1:0] exp_q [NREG];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_bank(input string req);
    for (int a = 0; a < NREG; a++) chk(req, 32'(regs[a*DW +: DW]), 32'(exp_q[a]));
  endtask

  task automatic xfer(input logic [7:0] op, input logic [7:0] ad, input logic [15:0] d,
                      input int nbits, input int pause,
                      output logic [15:0] rd, output int busy);
    logic [31:0] fr;
    fr = {op, ad, d};
    rd = '0;
    clks(1);
    cs_n = 1'b0;
    clks(H);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 32) ? fr[31-i] : 1'b1;
      clks(H + pause);
      if (i >= 16 && i < 32) rd = {rd[14:0], sdo};
      if (i == 20) chk("R10 oe during frame", 32'(sdo_oe), 32'd1);
      sck = 1'b1;
      clks(H + pause);
      sck = 1'b0;
    end
    clks(H);
    cs_n = 1'b1;
    busy = 0;
    for (int k = 0; k < 64; k++) begin
      clks(1);
      if (!rdy) busy++;
    end
  endtask

  function automatic logic [15:0] pat(input int a, input int p);
    logic [15:0] v;
    v = 16'(a * 16'h1357) ^ 16'hA5C3;
    return p[0] ? ~v : v;
  endfunction

  initial begin
    logic [15:0] rd;
    int busy;
    for (int a = 0; a < NREG; a++) exp_q[a] = '0;
    clks(3);
    rst_n = 1'b1;
    clks(3);

    // R1 reset state
    chk("R1 rdy", 32'(rdy), 32'd1);
    chk("R1 oe", 32'(sdo_oe), 32'd0);
    chk_bank("R1 regs zero");

    // R6 R3: read every register after reset
    for (int a = 0; a < NREG; a++) begin
      xfer(8'h03, 8'(a), 16'hFFFF, 32, 0, rd, busy);
      chk("R3 read zero", 32'(rd), 32'd0);
      chk("R6 read busy", 32'(busy), 32'(RDB));
    end

    // R2 R4 R5 R11 R3: write every register twice, read back with other upper nibble
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < NREG; a++) begin
        logic [3:0] up;
        up = 4'(a * 3 + p * 5);
        xfer(8'h02, {up, 4'(a)}, pat(a, p), 32, 0, rd, busy);
        exp_q[a] = pat(a, p);
        chk("R5 write busy", 32'(busy), 32'(WRB));
        chk("R11 regs slice", 32'(regs[a*DW +: DW]), 32'(pat(a, p)));
        xfer(8'h03, {~up, 4'(a)}, 16'h0000, 32, 0, rd, busy);
        chk("R4 R3 readback", 32'(rd), 32'(pat(a, p)));
      end
    end
    chk_bank("R2 R4 bank after sweep");

    // R7 unknown opcodes
    begin
      logic [7:0] ops [7] = '{8'h00, 8'h01, 8'h04, 8'h07, 8'h83, 8'hFF, 8'h12};
      for (int i = 0; i < 7; i++) begin
        xfer(ops[i], 8'h03, 16'hDEAD, 32, 0, rd, busy);
        chk("R7 no busy", 32'(busy), 32'd0);
      end
      chk_bank("R7 bank unchanged");
    end

    // R8 aborted frames
    begin
      int lens [5] = '{31, 24, 20, 8, 0};
      for (int i = 0; i < 5; i++) begin
        xfer(8'h02, 8'h09, 16'h1234, lens[i], 0, rd, busy);
        chk("R8 abort no busy", 32'(busy), 32'd0);
      end
      xfer(8'h03, 8'h09, 16'h0, 24, 0, rd, busy);
      chk("R8 read abort no busy", 32'(busy), 32'd0);
      chk_bank("R8 bank unchanged");
    end

    // R9 long pauses between edges
    xfer(8'h02, 8'hC0 | 8'd12, 16'h5AF0, 32, 37, rd, busy);
    exp_q[12] = 16'h5AF0;
    chk("R9 paused write busy", 32'(busy), 32'(WRB));
    chk("R9 paused write", 32'(regs[12*DW +: DW]), 32'h5AF0);
    xfer(8'h03, 8'd12, 16'h0, 32, 23, rd, busy);
    chk("R9 paused read", 32'(rd), 32'h5AF0);

    // R2 bits after the 32nd ignored
    xfer(8'h02, 8'd2, 16'h8001, 40, 0, rd, busy);
    exp_q[2] = 16'h8001;
    chk("R2 extra bits busy", 32'(busy), 32'(WRB));
    chk_bank("R2 extra bits ignored");

    // R10 idle oe
    chk("R10 oe idle", 32'(sdo_oe), 32'd0);
    chk("R5 R6 rdy idle", 32'(rdy), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule